// File: doc/BRIEF.md
# Calendar time-of-day counter

This block holds a complete wall-clock calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each single-cycle pulse on the tick input advances the calendar by one second, carrying through minutes, hours, days, months and years. February has 29 days in leap years.

The count is kept internally in plain binary. The seven output bytes are built from it on every cycle, in the representation chosen by two mode inputs. One mode selects BCD or binary. The other selects 24-hour form, or 12-hour form with a PM flag.

A host loads all seven fields at once with a load strobe. The load bytes are interpreted in the same representation that the mode inputs select for the outputs. The century needed for the leap-year rule comes from a separate binary input, normally held at 20.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the internal count is zero for seconds, minutes, hours, day of week and year, and one for day of month and month.
- R2: A tick adds one second. Seconds count 0 to 59 and wrap to 0 while adding one minute. Minutes count 0 to 59 and wrap to 0 while adding one hour. Hours count 0 to 23 and wrap to 0, which starts a new day.
- R3: At each new day, the day of week (0 to 6) advances, and 6 wraps to 0.
- R4: At each new day, the day of month advances. When it would exceed the month's length, it returns to 1 and the month advances. Month lengths are: 30 days for months 4, 6, 9 and 11; 28 or 29 days for month 2; 31 days for every other month value.
- R5: February has 29 days when the full year (century input × 100 + year) is divisible by 4, except a year divisible by 100 and not by 400.
- R6: Months are numbered 1 to 12. Advancing past 12 gives 1 and advances the year. The year runs 0 to 99, and 99 wraps to 0.
- R7: With bin_mode_i = 0, each output byte and each load byte is BCD: tens digit in bits 7:4, units digit in bits 3:0. With bin_mode_i = 1, each byte is the plain binary value.
- R8: With hr24_i = 0, the hours byte carries the hour modulo 12 in bits 6:0, and bit 7 is set for hours 12 to 23. On load in this mode, bit 7 is removed before decoding, and 12 is added when it was set. With hr24_i = 1, the hours byte carries 0 to 23.
- R9: A load strobe captures all seven fields in one clock. The loaded values appear on the outputs after that edge. A tick in the same cycle as a load is ignored.
- R10: With neither tick nor load, the count holds. Changing a mode input changes only how the outputs represent the count, never the count itself.
- R11: A day of month of 0 becomes 1 on the next day increment, with no change of month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-second advance pulse |
| load_i | input | 1 | Parallel load strobe for all fields |
| bin_mode_i | input | 1 | 1: binary bytes, 0: BCD bytes |
| hr24_i | input | 1 | 1: 24-hour hours byte, 0: 12-hour with PM in bit 7 |
| century_i | input | 7 | Binary century for the leap-year rule (normally 20) |
| ld_sec_i | input | 8 | Seconds byte to load |
| ld_min_i | input | 8 | Minutes byte to load |
| ld_hour_i | input | 8 | Hours byte to load |
| ld_wday_i | input | 8 | Day-of-week byte to load |
| ld_mday_i | input | 8 | Day-of-month byte to load |
| ld_mon_i | input | 8 | Month byte to load |
| ld_year_i | input | 8 | Year byte to load |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| wday_o | output | 8 | Day-of-week byte |
| mday_o | output | 8 | Day-of-month byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte |

## Verification
The count is stored once and only re-encoded on the way out, so a wrong stored field shows on its output byte in the cycle right after the edge that wrote it. A carry error is different: it stays hidden until the faulty boundary is crossed, for example a missing leap day or a missed month carry at the end of a 30-day month. The bench therefore loads times a few seconds before each boundary and compares every byte after every tick. A decode fault and its matching encode fault can cancel in a round trip. To catch that, the bench reloads in one representation and reads in the other, which shows such a fault at the next output sample.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned FW = 8;
  localparam int unsigned CW = 7;

  typedef struct packed {
    logic [FW-1:0] sec;
    logic [FW-1:0] min;
    logic [FW-1:0] hour;
    logic [FW-1:0] wday;
    logic [FW-1:0] mday;
    logic [FW-1:0] mon;
    logic [FW-1:0] year;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{sec: '0, min: '0, hour: '0, wday: '0,
                                      mday: FW'(1), mon: FW'(1), year: '0};

  function automatic logic [FW-1:0] bcd_to_bin(input logic [FW-1:0] v);
    return (FW'(v[7:4]) * FW'(10)) + FW'(v[3:0]);
  endfunction

  function automatic logic [FW-1:0] bin_to_bcd(input logic [FW-1:0] v);
    logic [FW-1:0] tens;
    logic [FW-1:0] ones;
    tens = v / FW'(10);
    ones = v % FW'(10);
    return {tens[3:0], ones[3:0]};
  endfunction
endpackage

// File: rtl/rtc_load_decode.sv
module rtc_load_decode
  import rtc_pkg::*;
(
  input  rtc_time_t raw_i,
  input  logic      bin_mode_i,
  input  logic      hr24_i,
  output rtc_time_t dec_o
);
  logic [FW-1:0] hour_body;
  logic [FW-1:0] hour_val;

  always_comb begin
    hour_body = hr24_i ? raw_i.hour : {1'b0, raw_i.hour[FW-2:0]};
    hour_val  = bin_mode_i ? hour_body : bcd_to_bin(hour_body);
    if (!hr24_i && raw_i.hour[FW-1]) hour_val = hour_val + FW'(12);
  end

  always_comb begin
    if (bin_mode_i) begin
      dec_o = raw_i;
    end else begin
      dec_o.sec  = bcd_to_bin(raw_i.sec);
      dec_o.min  = bcd_to_bin(raw_i.min);
      dec_o.hour = '0;
      dec_o.wday = bcd_to_bin(raw_i.wday);
      dec_o.mday = bcd_to_bin(raw_i.mday);
      dec_o.mon  = bcd_to_bin(raw_i.mon);
      dec_o.year = bcd_to_bin(raw_i.year);
    end
    dec_o.hour = hour_val;
  end
endmodule

// File: rtl/rtc_out_encode.sv
module rtc_out_encode
  import rtc_pkg::*;
(
  input  rtc_time_t cnt_i,
  input  logic      bin_mode_i,
  input  logic      hr24_i,
  output rtc_time_t enc_o
);
  logic [FW-1:0] hour_base;
  logic          pm;
  logic [FW-1:0] hour_enc;

  always_comb begin
    pm        = cnt_i.hour >= FW'(12);
    hour_base = hr24_i ? cnt_i.hour : (cnt_i.hour % FW'(12));
    hour_enc  = bin_mode_i ? hour_base : bin_to_bcd(hour_base);
    if (!hr24_i) hour_enc[FW-1] = pm;
  end

  always_comb begin
    if (bin_mode_i) begin
      enc_o = cnt_i;
    end else begin
      enc_o.sec  = bin_to_bcd(cnt_i.sec);
      enc_o.min  = bin_to_bcd(cnt_i.min);
      enc_o.hour = '0;
      enc_o.wday = bin_to_bcd(cnt_i.wday);
      enc_o.mday = bin_to_bcd(cnt_i.mday);
      enc_o.mon  = bin_to_bcd(cnt_i.mon);
      enc_o.year = bin_to_bcd(cnt_i.year);
    end
    enc_o.hour = hour_enc;
  end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  rtc_time_t     cur_i,
  input  logic [CW-1:0] century_i,
  output rtc_time_t     nxt_o
);
  logic          leap;
  logic [FW-1:0] month_len;
  logic [FW-1:0] sec_inc, min_inc, hour_inc, wday_inc, mday_inc, mon_inc, year_inc;

  always_comb begin
    leap = (cur_i.year[1:0] == 2'b00) &&
           ((cur_i.year != '0) || ((century_i % CW'(4)) == '0));
    case (cur_i.mon)
      FW'(2):                             month_len = leap ? FW'(29) : FW'(28);
      FW'(4), FW'(6), FW'(9), FW'(11):    month_len = FW'(30);
      default:                            month_len = FW'(31);
    endcase
  end

  always_comb begin
    sec_inc  = cur_i.sec  + FW'(1);
    min_inc  = cur_i.min  + FW'(1);
    hour_inc = cur_i.hour + FW'(1);
    wday_inc = cur_i.wday + FW'(1);
    mday_inc = cur_i.mday + FW'(1);
    mon_inc  = cur_i.mon  + FW'(1);
    year_inc = cur_i.year + FW'(1);
    nxt_o     = cur_i;
    nxt_o.sec = sec_inc;
    if (sec_inc >= FW'(60)) begin
      nxt_o.sec = '0;
      nxt_o.min = min_inc;
      if (min_inc >= FW'(60)) begin
        nxt_o.min  = '0;
        nxt_o.hour = hour_inc;
        if (hour_inc >= FW'(24)) begin
          nxt_o.hour = '0;
          nxt_o.wday = (wday_inc >= FW'(7)) ? '0 : wday_inc;
          nxt_o.mday = mday_inc;
          if (mday_inc < FW'(1)) begin
            nxt_o.mday = FW'(1);
          end else if (mday_inc > month_len) begin
            nxt_o.mday = FW'(1);
            nxt_o.mon  = mon_inc;
            if (mon_inc > FW'(12)) begin
              nxt_o.mon  = FW'(1);
              nxt_o.year = (year_inc >= FW'(100)) ? '0 : year_inc;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic          bin_mode_i,
  input  logic          hr24_i,
  input  logic [CW-1:0] century_i,
  input  logic [FW-1:0] ld_sec_i,
  input  logic [FW-1:0] ld_min_i,
  input  logic [FW-1:0] ld_hour_i,
  input  logic [FW-1:0] ld_wday_i,
  input  logic [FW-1:0] ld_mday_i,
  input  logic [FW-1:0] ld_mon_i,
  input  logic [FW-1:0] ld_year_i,
  output logic [FW-1:0] sec_o,
  output logic [FW-1:0] min_o,
  output logic [FW-1:0] hour_o,
  output logic [FW-1:0] wday_o,
  output logic [FW-1:0] mday_o,
  output logic [FW-1:0] mon_o,
  output logic [FW-1:0] year_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  rtc_time_t  time_q, time_d, time_ld, time_adv, time_enc, raw_ld;
  logic       upd_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign raw_ld = '{sec: ld_sec_i, min: ld_min_i, hour: ld_hour_i, wday: ld_wday_i,
                    mday: ld_mday_i, mon: ld_mon_i, year: ld_year_i};

  rtc_load_decode u_dec (.raw_i(raw_ld), .bin_mode_i(bin_mode_i), .hr24_i(hr24_i),
                         .dec_o(time_ld));
  rtc_advance     u_adv (.cur_i(time_q), .century_i(century_i), .nxt_o(time_adv));
  rtc_out_encode  u_enc (.cnt_i(time_q), .bin_mode_i(bin_mode_i), .hr24_i(hr24_i),
                         .enc_o(time_enc));

  always_comb begin
    upd_en = load_i || tick_i;
    time_d = load_i ? time_ld : time_adv;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  time_q <= RTC_RESET;
    else if (upd_en)  time_q <= time_d;
  end

  assign sec_o  = time_enc.sec;
  assign min_o  = time_enc.min;
  assign hour_o = time_enc.hour;
  assign wday_o = time_enc.wday;
  assign mday_o = time_enc.mday;
  assign mon_o  = time_enc.mon;
  assign year_o = time_enc.year;
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker
  import rtc_pkg::*;
(
  input logic          clk_i,
  input logic          rst_n,
  input logic          tick_i,
  input logic          load_i,
  input logic          bin_mode_i,
  input logic          hr24_i,
  input logic [FW-1:0] ld_sec_i,
  input logic [FW-1:0] ld_hour_i,
  input rtc_time_t     cur
);
  assert_load_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (load_i && bin_mode_i && hr24_i) |=> (cur.sec == $past(ld_sec_i)) && (cur.hour == $past(ld_hour_i)));

  assert_load_over_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (load_i && tick_i && bin_mode_i) |=> (cur.sec == $past(ld_sec_i)));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cur));

  assert_sec_step_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_i && !load_i && cur.sec < FW'(59)) |=> (cur.sec == $past(cur.sec) + FW'(1)) && $stable(cur.min));

  assert_sec_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_i && !load_i && cur.sec == FW'(59)) |=> (cur.sec == '0) && !$stable(cur.min));

  assert_year_end_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_i && !load_i && cur.sec == FW'(59) && cur.min == FW'(59) && cur.hour == FW'(23) &&
     cur.mday == FW'(31) && cur.mon == FW'(12)) |=> (cur.mon == FW'(1)) && (cur.mday == FW'(1)));
endmodule

bind rtc_calendar_core rtc_calendar_checker u_chk (
  .clk_i(clk_i), .rst_n(rst_sync_n), .tick_i(tick_i), .load_i(load_i),
  .bin_mode_i(bin_mode_i), .hr24_i(hr24_i), .ld_sec_i(ld_sec_i),
  .ld_hour_i(ld_hour_i), .cur(time_q)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, load = 1'b0, bin_mode = 1'b0, hr24 = 1'b1;
  logic [6:0] century = 7'd20;
  logic [7:0] l_sec = 0, l_min = 0, l_hour = 0, l_wday = 0, l_mday = 0, l_mon = 0, l_year = 0;
  logic [7:0] o_sec, o_min, o_hour, o_wday, o_mday, o_mon, o_year;
  int tests = 0, fails = 0;
  int ms, mm, mh, mw, md, mo, my;

  always #10 clk = ~clk;

  rtc_calendar_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .load_i(load), .bin_mode_i(bin_mode),
    .hr24_i(hr24), .century_i(century),
    .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hour), .ld_wday_i(l_wday),
    .ld_mday_i(l_mday), .ld_mon_i(l_mon), .ld_year_i(l_year),
    .sec_o(o_sec), .min_o(o_min), .hour_o(o_hour), .wday_o(o_wday),
    .mday_o(o_mday), .mon_o(o_mon), .year_o(o_year));

  function automatic logic [7:0] enc(int v, logic b);
    return b ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] enc_hour(int h, logic b, logic h24);
    if (h24) return enc(h, b);
    return enc(h % 12, b) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int month_days(int mon, int yr, int cen);
    int full = cen * 100 + yr;
    bit lp = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    if (mon == 2) return lp ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    ms++;
    if (ms >= 60) begin
      ms = 0; mm++;
      if (mm >= 60) begin
        mm = 0; mh++;
        if (mh >= 24) begin
          mh = 0;
          mw = (mw + 1) % 7;
          md++;
          if (md < 1) md = 1;
          else if (md > month_days(mo, my, int'(century))) begin
            md = 1; mo++;
            if (mo > 12) begin mo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " sec"},  o_sec,  enc(ms, bin_mode));
    chk({tag, " min"},  o_min,  enc(mm, bin_mode));
    chk({tag, " hour"}, o_hour, enc_hour(mh, bin_mode, hr24));
    chk({tag, " wday"}, o_wday, enc(mw, bin_mode));
    chk({tag, " mday"}, o_mday, enc(md, bin_mode));
    chk({tag, " mon"},  o_mon,  enc(mo, bin_mode));
    chk({tag, " year"}, o_year, enc(my, bin_mode));
  endtask

  // R9: load with the current modes; with_tick also pulses tick in the same cycle
  task automatic do_load(int s, int m, int h, int w, int d, int mon, int y, bit with_tick, string tag);
    l_sec = enc(s, bin_mode); l_min = enc(m, bin_mode); l_hour = enc_hour(h, bin_mode, hr24);
    l_wday = enc(w, bin_mode); l_mday = enc(d, bin_mode); l_mon = enc(mon, bin_mode);
    l_year = enc(y, bin_mode);
    load = 1'b1; tick = with_tick;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
    ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y;
    check_all(tag);
  endtask

  task automatic do_ticks(int n, string tag);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      model_tick();
      check_all(tag);
    end
    tick = 1'b0;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    ms = 0; mm = 0; mh = 0; mw = 0; md = 1; mo = 1; my = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");

    do_ticks(3, "R2 first ticks");
    // R10: no stimulus, state holds
    repeat (5) @(negedge clk);
    check_all("R10 idle");

    // R2 carries through minute and hour, R3 wday 6 -> 0
    do_load(58, 59, 23, 6, 10, 5, 24, 0, "R9 load");
    do_ticks(3, "R2 R3 midnight");

    // R4 30-day month carry
    do_load(59, 59, 23, 2, 30, 4, 23, 0, "R9 load");
    do_ticks(1, "R4 april end");
    // R5 leap years: 2024 leap, 2023 not, 2000 leap, 2100 not
    do_load(59, 59, 23, 0, 28, 2, 24, 0, "R9 load");
    do_ticks(1, "R5 2024 feb28");
    do_ticks(86400, "R5 2024 feb29 day");
    do_load(59, 59, 23, 0, 28, 2, 23, 0, "R9 load");
    do_ticks(1, "R5 2023 feb28");
    do_load(59, 59, 23, 0, 28, 2, 0, 0, "R9 load");
    do_ticks(1, "R5 2000 feb28");
    century = 7'd21;
    do_load(59, 59, 23, 0, 28, 2, 0, 0, "R9 load");
    do_ticks(1, "R5 2100 feb28");
    century = 7'd20;

    // R6 year end and 99 -> 0
    do_load(58, 59, 23, 3, 31, 12, 99, 0, "R9 load");
    do_ticks(3, "R6 year wrap");

    // R8 12-hour mode, BCD: 11 PM load then midnight roll
    hr24 = 1'b0;
    do_load(59, 59, 23, 1, 5, 6, 30, 0, "R8 pm load");
    chk("R8 pm byte", o_hour, 8'h91);
    do_ticks(1, "R8 midnight 12h");
    chk("R8 midnight byte", o_hour, 8'h00);
    do_load(59, 59, 11, 1, 5, 6, 30, 0, "R8 am load");
    do_ticks(1, "R8 noon");
    chk("R8 noon byte", o_hour, 8'h80);

    // R7 R10 mode switches re-encode without changing the count
    bin_mode = 1'b1; @(negedge clk); check_all("R7 R10 to binary");
    hr24 = 1'b1;     @(negedge clk); check_all("R8 R10 to 24h");
    chk("R7 hour binary", o_hour, 8'd12);
    bin_mode = 1'b0; @(negedge clk); check_all("R7 R10 to bcd");
    chk("R7 hour bcd", o_hour, 8'h12);

    // R9 load beats a tick in the same cycle
    do_load(10, 20, 5, 4, 15, 8, 45, 1, "R9 load over tick");

    // R11 day of month 0 forced to 1
    bin_mode = 1'b1;
    do_load(59, 59, 23, 0, 0, 3, 10, 0, "R11 load");
    do_ticks(1, "R11 mday zero");

    // random mix of modes and near-boundary times
    for (int it = 0; it < 400; it++) begin
      int s, m, h, d, mon, y, lim;
      bin_mode = $urandom_range(0, 1);
      hr24 = $urandom_range(0, 1);
      century = 7'($urandom_range(17, 23));
      s = ($urandom_range(0, 2) == 0) ? 59 : $urandom_range(0, 59);
      m = ($urandom_range(0, 1) == 0) ? 59 : $urandom_range(0, 59);
      h = ($urandom_range(0, 1) == 0) ? 23 : $urandom_range(0, 23);
      mon = $urandom_range(1, 12);
      y = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 0) ? 0 : 99) : $urandom_range(0, 99);
      lim = month_days(mon, y, int'(century));
      d = ($urandom_range(0, 1) == 0) ? lim : $urandom_range(1, lim);
      do_load(s, m, h, $urandom_range(0, 6), d, mon, y, 0, "R9 R7 R8 rand load");
      do_ticks($urandom_range(1, 3), "R2 R3 R4 R5 R6 rand tick");
      if ($urandom_range(0, 3) == 0) begin
        repeat (2) @(negedge clk);
        check_all("R10 rand idle");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule